// File: doc/BRIEF.md
# DRAM Rank Power-State Manager

This block decides, cycle by cycle, the clock-enable level of every DRAM rank on one memory channel. Each populated rank is in one of four basic conditions: awake with clock enable high, power-down with all banks closed, power-down with some bank still open, or self-refresh. A fifth, transient condition covers the wake-up window after self-refresh, during which the clock enable is already high but no commands may be issued yet.

The choice between a power-down and self-refresh follows the package idle depth. While the package is only lightly idle, ranks use dynamic power-down after a programmable run of idle cycles. While it is deeply idle, self-refresh is used, but only when the graphics engine is idle and no display fetch is pending; otherwise dynamic power-down is still used. The kind of power-down follows the per-rank bank-open flag. A pending request to a rank brings its clock enable back up, and the command scheduler is told through a per-rank permit when commands may go out. The timing limits are reduced to two programmable counts: idle cycles before power-down and the hold-off after self-refresh exit.

Ranks whose connector is empty are held awake, never change state, and have their output drivers switched to high impedance.

Top module: `dram_rank_pm`

## Requirements
- R1: A synchronous active-high reset puts every rank in the awake state (code 0) with clock enable high, command permit high and both self-refresh strobes low.
- R2: An awake populated rank keeps clock enable high and leaves the awake state at the clock edge that completes `idle_limit` consecutive cycles without a request (a limit of 0 acts as 1); any request restarts the count.
- R3: When that idle run completes and self-refresh is not allowed and the rank's bank-open flag is low, the rank enters power-down with banks closed (code 1) with clock enable low.
- R4: When that idle run completes and self-refresh is not allowed and the bank-open flag is high, the rank enters power-down with a bank open (code 2) with clock enable low.
- R5: Self-refresh is allowed only when deep package idle is set, graphics is idle and no display request is pending; an allowed idle completion enters self-refresh (code 3) with clock enable low; with light idle self-refresh is never entered.
- R6: A rank in either power-down returns to the awake state at the next edge when a request is present; without a request and with self-refresh allowed it moves directly to self-refresh.
- R7: A rank in self-refresh leaves it when a request arrives or self-refresh stops being allowed, entering the exit state (code 4) with clock enable high, and stays there for `exit_limit` cycles (0 acts as 1) before becoming awake.
- R8: `sr_enter` for a rank is high for exactly the first cycle that rank is in self-refresh, `sr_exit` for exactly the first cycle in the exit state; never both.
- R9: The command permit of a rank is high only in the awake state.
- R10: `rank_hiz` of a rank equals the inverse of its populated flag; an unpopulated rank stays awake with clock enable high and never pulses a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rank_populated | input | NUM_RANKS | Connector populated, per rank |
| rank_bank_open | input | NUM_RANKS | At least one bank open, per rank |
| rank_req | input | NUM_RANKS | Request pending for the rank |
| idle_limit | input | CNT_W | Idle cycles before leaving the awake state |
| exit_limit | input | CNT_W | Command hold-off cycles after self-refresh exit |
| pkg_deep_idle | input | 1 | Package in deep idle |
| gfx_idle | input | 1 | Graphics engine idle |
| disp_req_pending | input | 1 | Display request pending |
| cke | output | NUM_RANKS | Clock enable, per rank |
| cmd_allow | output | NUM_RANKS | Commands may be issued, per rank |
| rank_state | output | 3*NUM_RANKS | State code per rank (0 awake, 1 closed-bank power-down, 2 open-bank power-down, 3 self-refresh, 4 exit) |
| sr_enter | output | NUM_RANKS | Self-refresh entry strobe, per rank |
| sr_exit | output | NUM_RANKS | Self-refresh exit strobe, per rank |
| rank_hiz | output | NUM_RANKS | Output drivers tri-stated, per rank |

## Verification
The bench builds the block with two ranks and an 8-bit count width, which keeps the per-rank logic replicated by the generate loop while leaving both limits small enough to sweep. It drives the limits at 3 and 4, then at 0 and 0, then at 1 and 6, so the zero-as-one rule, the shortest idle run and a long exit hold-off are all reached. One phase leaves the second rank unpopulated, and the slowly changing idle-depth, graphics and display flags let random runs reach self-refresh entry, exit on a request and exit on loss of permission.

// File: rtl/dram_pm_pkg.sv
package dram_pm_pkg;

    typedef enum logic [2:0] {
        PS_AWAKE  = 3'd0,
        PS_PD_CLS = 3'd1,
        PS_PD_OPN = 3'd2,
        PS_SREF   = 3'd3,
        PS_SRX    = 3'd4
    } pstate_e;

    // clock enable level carried by each state
    function automatic logic cke_of(input pstate_e s);
        return !(s == PS_PD_CLS || s == PS_PD_OPN || s == PS_SREF);
    endfunction

    // low-power target once the idle run completes
    function automatic pstate_e idle_target(input logic sr_ok, input logic bank_open);
        if (sr_ok)
            return PS_SREF;
        return bank_open ? PS_PD_OPN : PS_PD_CLS;
    endfunction

endpackage

// File: rtl/pm_policy.sv
module pm_policy (
    input  logic clk,
    input  logic rst,
    input  logic pkg_deep_idle,
    input  logic gfx_idle,
    input  logic disp_req_pending,
    output logic sr_ok
);
    assign sr_ok = pkg_deep_idle && gfx_idle && !disp_req_pending;

    // R5
    sr_needs_deep_chk: assert property (@(posedge clk) disable iff (rst)
        !pkg_deep_idle |-> !sr_ok);
endmodule

// File: rtl/rank_pwr_fsm.sv
module rank_pwr_fsm
    import dram_pm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             populated,
    input  logic             bank_open,
    input  logic             req,
    input  logic             sr_ok,
    input  logic [CNT_W-1:0] idle_lim,
    input  logic [CNT_W-1:0] exit_lim,
    output logic             cke,
    output logic             cmd_ok,
    output logic [2:0]       state_code,
    output logic             sr_enter,
    output logic             sr_exit
);
    localparam int CW1 = CNT_W + 1;

    pstate_e          st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ent_d, ext_d;
    logic             idle_done, exit_done;

    assign idle_done = ({1'b0, cnt_q} + CW1'(1)) >= {1'b0, idle_lim};
    assign exit_done = ({1'b0, cnt_q} + CW1'(1)) >= {1'b0, exit_lim};

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        ent_d = 1'b0;
        ext_d = 1'b0;
        if (!populated) begin
            st_d  = PS_AWAKE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                PS_AWAKE: begin
                    if (req) begin
                        cnt_d = '0;
                    end else if (idle_done) begin
                        st_d  = idle_target(sr_ok, bank_open);
                        ent_d = sr_ok;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PS_PD_CLS, PS_PD_OPN: begin
                    if (req) begin
                        st_d  = PS_AWAKE;
                        cnt_d = '0;
                    end else if (sr_ok) begin
                        st_d  = PS_SREF;
                        ent_d = 1'b1;
                    end
                end
                PS_SREF: begin
                    if (req || !sr_ok) begin
                        st_d  = PS_SRX;
                        ext_d = 1'b1;
                        cnt_d = '0;
                    end
                end
                PS_SRX: begin
                    if (exit_done) begin
                        st_d  = PS_AWAKE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    st_d  = PS_AWAKE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= PS_AWAKE;
            cnt_q    <= '0;
            sr_enter <= 1'b0;
            sr_exit  <= 1'b0;
        end else begin
            st_q     <= st_d;
            cnt_q    <= cnt_d;
            sr_enter <= ent_d;
            sr_exit  <= ext_d;
        end
    end

    assign cke        = cke_of(st_q);
    assign cmd_ok     = (st_q == PS_AWAKE);
    assign state_code = st_q;

    // R2
    req_keeps_awake_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_AWAKE && req) |=> (st_q == PS_AWAKE));
    // R3
    open_bank_not_pdcls_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_AWAKE && bank_open) |=> (st_q != PS_PD_CLS));
    // R5
    sr_only_when_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != PS_SREF && !sr_ok) |=> (st_q != PS_SREF));
    // R7
    sr_leaves_via_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_SREF) |=> (st_q == PS_SREF || st_q == PS_SRX));
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sr_enter, sr_exit}));
    // R6
    pd_wake_chk: assert property (@(posedge clk) disable iff (rst)
        ((st_q == PS_PD_CLS || st_q == PS_PD_OPN) && req && populated) |=> cke);
    // R10
    empty_stays_awake_chk: assert property (@(posedge clk) disable iff (rst)
        !populated |=> (st_q == PS_AWAKE));
endmodule

// File: rtl/dram_rank_pm.sv
module dram_rank_pm
    import dram_pm_pkg::*;
#(
    parameter int NUM_RANKS = 2,
    parameter int CNT_W     = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_RANKS-1:0]   rank_populated,
    input  logic [NUM_RANKS-1:0]   rank_bank_open,
    input  logic [NUM_RANKS-1:0]   rank_req,
    input  logic [CNT_W-1:0]       idle_limit,
    input  logic [CNT_W-1:0]       exit_limit,
    input  logic                   pkg_deep_idle,
    input  logic                   gfx_idle,
    input  logic                   disp_req_pending,
    output logic [NUM_RANKS-1:0]   cke,
    output logic [NUM_RANKS-1:0]   cmd_allow,
    output logic [3*NUM_RANKS-1:0] rank_state,
    output logic [NUM_RANKS-1:0]   sr_enter,
    output logic [NUM_RANKS-1:0]   sr_exit,
    output logic [NUM_RANKS-1:0]   rank_hiz
);
    logic sr_ok;

    pm_policy u_policy (
        .clk              (clk),
        .rst              (rst),
        .pkg_deep_idle    (pkg_deep_idle),
        .gfx_idle         (gfx_idle),
        .disp_req_pending (disp_req_pending),
        .sr_ok            (sr_ok)
    );

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        rank_pwr_fsm #(.CNT_W(CNT_W)) u_fsm (
            .clk        (clk),
            .rst        (rst),
            .populated  (rank_populated[r]),
            .bank_open  (rank_bank_open[r]),
            .req        (rank_req[r]),
            .sr_ok      (sr_ok),
            .idle_lim   (idle_limit),
            .exit_lim   (exit_limit),
            .cke        (cke[r]),
            .cmd_ok     (cmd_allow[r]),
            .state_code (rank_state[3*r +: 3]),
            .sr_enter   (sr_enter[r]),
            .sr_exit    (sr_exit[r])
        );
    end

    assign rank_hiz = ~rank_populated;

    // R9
    permit_needs_cke_chk: assert property (@(posedge clk) disable iff (rst)
        ((cmd_allow & ~cke) == '0));
endmodule

// File: tb/dram_rank_pm_test.sv
module dram_rank_pm_test;
    localparam int NR = 2;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NR-1:0] pop = '1, bopen = '0, req = '0;
    logic [CW-1:0] ith = 8'd3, xlat = 8'd4;
    logic deep = 1'b0, gidle = 1'b0, disp = 1'b0;
    logic [NR-1:0] cke, cmd_allow, sr_enter, sr_exit, hiz;
    logic [3*NR-1:0] rstate;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 1'b0;

    int unsigned m_st [NR];
    int unsigned m_cnt[NR];
    bit m_ent[NR], m_ext[NR];

    always #10 clk = ~clk;

    dram_rank_pm #(.NUM_RANKS(NR), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .rank_populated(pop), .rank_bank_open(bopen),
        .rank_req(req), .idle_limit(ith), .exit_limit(xlat),
        .pkg_deep_idle(deep), .gfx_idle(gidle), .disp_req_pending(disp),
        .cke(cke), .cmd_allow(cmd_allow), .rank_state(rstate),
        .sr_enter(sr_enter), .sr_exit(sr_exit), .rank_hiz(hiz)
    );

    function automatic int unsigned lim1(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic bit exp_cke(input int unsigned s);
        return !(s == 1 || s == 2 || s == 3);
    endfunction

    function automatic string st_req(input int unsigned s);
        case (s)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R7";
        endcase
    endfunction

    // reference model, advanced at each rising edge from the requirements
    always @(posedge clk) begin
        bit ok;
        ok = deep && gidle && !disp;
        for (int r = 0; r < NR; r++) begin
            m_ent[r] = 1'b0;
            m_ext[r] = 1'b0;
            if (rst || !pop[r]) begin
                m_st[r] = 0; m_cnt[r] = 0;
            end else begin
                case (m_st[r])
                    0: if (req[r]) m_cnt[r] = 0;
                       else if (m_cnt[r] + 1 >= lim1(ith)) begin
                           m_st[r] = ok ? 3 : (bopen[r] ? 2 : 1);
                           m_ent[r] = ok; m_cnt[r] = 0;
                       end else m_cnt[r]++;
                    1, 2: if (req[r]) begin m_st[r] = 0; m_cnt[r] = 0; end
                          else if (ok) begin m_st[r] = 3; m_ent[r] = 1'b1; end
                    3: if (req[r] || !ok) begin
                           m_st[r] = 4; m_ext[r] = 1'b1; m_cnt[r] = 0;
                       end
                    default: if (m_cnt[r] + 1 >= lim1(xlat)) begin
                           m_st[r] = 0; m_cnt[r] = 0;
                       end else m_cnt[r]++;
                endcase
            end
        end
    end

    task automatic chk(input bit good, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", rq, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        for (int r = 0; r < NR; r++) begin
            int s;
            s = int'(rstate[3*r +: 3]);
            chk(s == int'(m_st[r]), st_req(m_st[r]), "state", s, int'(m_st[r]));
            chk(cke[r] == exp_cke(m_st[r]), st_req(m_st[r]), "cke", int'(cke[r]), int'(exp_cke(m_st[r])));
            chk(cmd_allow[r] == (m_st[r] == 0), "R9", "cmd_allow", int'(cmd_allow[r]), int'(m_st[r] == 0));
            chk(sr_enter[r] == m_ent[r], "R8", "sr_enter", int'(sr_enter[r]), int'(m_ent[r]));
            chk(sr_exit[r] == m_ext[r], "R8", "sr_exit", int'(sr_exit[r]), int'(m_ext[r]));
            chk(hiz[r] == !pop[r], "R10", "hiz", int'(hiz[r]), int'(!pop[r]));
        end
    endtask

    task automatic rand_phase(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_all();
            for (int r = 0; r < NR; r++) begin
                req[r] = ($urandom % 9) == 0;
                if (($urandom % 16) == 0) bopen[r] = ~bopen[r];
            end
            if (($urandom % 40) == 0) deep  = ~deep;
            if (($urandom % 25) == 0) gidle = ~gidle;
            if (($urandom % 30) == 0) disp  = ~disp;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check_all();
        chk(cke == '1 && rstate == '0, "R1", "reset cke/state", int'(cke), 3);
        rst = 1'b0;

        // directed R3 then R6: idle run into closed-bank power-down, then wake
        for (int i = 0; i < 3; i++) begin @(negedge clk); check_all(); end
        chk(rstate[2:0] == 3'd1 && cke[0] == 1'b0, "R3", "pd closed", int'(rstate[2:0]), 1);
        req = 2'b01;
        @(negedge clk); check_all();
        chk(rstate[2:0] == 3'd0 && cke[0] == 1'b1, "R6", "pd wake", int'(rstate[2:0]), 0);
        req = '0; bopen = 2'b01;
        for (int i = 0; i < 3; i++) begin @(negedge clk); check_all(); end
        chk(rstate[2:0] == 3'd2, "R4", "pd open", int'(rstate[2:0]), 2);

        // directed R5/R7: deep idle allowed moves power-down into self-refresh, then exit
        deep = 1'b1; gidle = 1'b1;
        @(negedge clk); check_all();
        chk(rstate[2:0] == 3'd3 && sr_enter[0], "R5", "sr entry", int'(rstate[2:0]), 3);
        disp = 1'b1;
        @(negedge clk); check_all();
        chk(rstate[2:0] == 3'd4 && cke[0] && !cmd_allow[0], "R7", "sr exit", int'(rstate[2:0]), 4);
        disp = 1'b0; deep = 1'b0;
        for (int i = 0; i < 4; i++) begin @(negedge clk); check_all(); end

        rand_phase(3000);
        ith = 8'd0; xlat = 8'd0;
        rand_phase(3000);
        ith = 8'd1; xlat = 8'd6; pop = 2'b01;   // R10: rank 1 empty
        rand_phase(3000);
        pop = 2'b11;
        rand_phase(2000);
        rst = 1'b1;
        @(negedge clk); check_all();
        chk(cke == '1 && rstate == '0, "R1", "re-reset", int'(rstate), 0);
        done = 1'b1;
    end

    always @(posedge clk) begin
        cycles++;
        if (done || cycles > 150000) begin
            if (!done) begin
                checks++; fails++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            end
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule